// File: doc/BRIEF.md
# Multi-Source Reset Supervisor Controller

This synchronous controller produces one active-low system reset. It takes three digital supply-good flags, each from an external comparator: a primary rail, a secondary rail and a rail watched through an adjustable divider. It also takes an active-low push-button input. A fault on any source pulls the reset low. The reset is released only after every source has been healthy for a whole recovery interval. A set-up pin selects one of two interval lengths: a short one, nominally about 210 ms, or a long one, nominally about 900 ms.

Each asynchronous input passes through a two-flop synchronizer. The push-button then goes to a single run-length counter, which serves two purposes. In the normal mode it acts as a glitch filter: lows shorter than `FILT_CYC` sampled cycles are dropped. With the hold option enabled, the press must last a programmable number of cycles before it counts, and the design never allows that number to fall below a floor (`HOLD_MIN_CYC`). The default parameters are derived from `CLK_HZ`. At 50 MHz they give a 100 ns filter, a 6 us minimum hold, and recovery intervals of 210 ms and 900 ms.

Top module: `rsup_ctrl`

## Requirements
- R1: Each supply-good flag (1 = good) is synchronized through two flops. A flag that goes low drives `sys_rst_no` low on the third rising edge after the change, and holds it low while the flag stays low.
- R2: With `cfg_hold_en_i` = 0, a qualified push-button press (`btn_ni` = 0) drives `sys_rst_no` low. The press path adds 3 cycles of latency on top of the filter length.
- R3: After the last supply flag returns high, with the button released, `sys_rst_no` stays low for L more cycles and rises on edge L+3. Once released, it stays high while no fault is present.
- R4: `cfg_long_sel_i` = 1 selects L = `REC_LONG_CYC`. A value of 0 selects L = `REC_SHORT_CYC`.
- R5: With `cfg_hold_en_i` = 0, a button low lasting fewer than `FILT_CYC` consecutive sampled cycles has no effect. A low that lasts `FILT_CYC` cycles drives the reset low on edge `FILT_CYC`+3.
- R6: With `cfg_hold_en_i` = 1, the button must stay low for T = max(`cfg_hold_cyc_i`, `HOLD_MIN_CYC`) cycles. The reset then falls on edge T+3.
- R7: With the hold option on, releasing the button before T clears the run count. Later presses start from zero, so two short presses never add up to a reset.
- R8: The reset stays low for as long as the button is held. After release it rises on edge L+4.
- R9: A fault during the recovery count aborts the count. Counting restarts from zero once all sources are good again.
- R10: During the controller's own synchronous reset (`srst_ni` = 0) the output is low. With all sources good, it first rises on edge L+3 after `srst_ni` is deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| srst_ni | input | 1 | Synchronous active-low reset of the controller |
| pg_primary_i | input | 1 | Primary supply good (asynchronous) |
| pg_secondary_i | input | 1 | Secondary supply good (asynchronous) |
| pg_adjust_i | input | 1 | Adjustable-divider monitor good (asynchronous) |
| btn_ni | input | 1 | Push-button, low = pressed (asynchronous) |
| cfg_long_sel_i | input | 1 | 1 selects the long recovery interval |
| cfg_hold_en_i | input | 1 | 1 enables the press hold-time qualifier |
| cfg_hold_cyc_i | input | HOLD_W | Requested hold time in cycles (clamped to the floor) |
| sys_rst_no | output | 1 | Active-low system reset |

## Verification
The embedded properties check the following on every cycle:
- any synchronized supply fault or qualified press is followed by a low reset;
- the reset never rises unless the previous cycle was fault-free and counting;
- a released reset stays high while the sources stay clean;
- an aborted count goes back to zero;
- the synchronizer delay is exactly two cycles;
- a released button removes the press on the next cycle.

Only the bench scenarios can show the exact interval lengths:
- the short and long recovery counts;
- the filter and hold thresholds, including the clamp to the floor;
- that two short presses separated by a release do not combine;
- that the count restarts in full after a mid-interval glitch.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    typedef enum logic [1:0] {
        REC_HOLD  = 2'd0,
        REC_COUNT = 2'd1,
        REC_DONE  = 2'd2
    } rec_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned bits_for(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
    parameter int unsigned      WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             srst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stab;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_i;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk_i) begin
        if (!srst_ni) begin
            st_q <= '{meta: RST_VAL, stab: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stab;

    // R1: exactly two cycles from pin to synchronized value
    a_r1_two_stage: assert property (@(posedge clk_i) disable iff (!srst_ni)
        $past(srst_ni, 2) |-> (sync_o == $past(async_i, 2)));

endmodule

// File: rtl/rsup_btn_qual.sv
module rsup_btn_qual
    import rsup_pkg::*;
#(
    parameter int unsigned FILT_CYC     = 5,
    parameter int unsigned HOLD_MIN_CYC = 300,
    parameter int unsigned HOLD_W       = 32,
    parameter bit          HOLD_OPT     = 1'b1
) (
    input  logic              clk_i,
    input  logic              srst_ni,
    input  logic              btn_low_i,
    input  logic              hold_en_i,
    input  logic [HOLD_W-1:0] hold_cyc_i,
    output logic              press_o
);

    localparam int unsigned CNT_W =
        max2(HOLD_W, max2(bits_for(FILT_CYC), bits_for(HOLD_MIN_CYC)));

    typedef struct packed {
        logic [CNT_W-1:0] run;
    } qual_t;

    qual_t            q_d, q_q;
    logic [CNT_W-1:0] thr;

    generate
        if (HOLD_OPT) begin : g_hold
            logic [CNT_W-1:0] req;
            always_comb begin
                req = CNT_W'(hold_cyc_i);
                if (!hold_en_i) begin
                    thr = CNT_W'(FILT_CYC);
                end else if (req < CNT_W'(HOLD_MIN_CYC)) begin
                    thr = CNT_W'(HOLD_MIN_CYC);
                end else begin
                    thr = req;
                end
            end
        end else begin : g_nohold
            logic unused_cfg;
            assign unused_cfg = ^{hold_en_i, hold_cyc_i};
            assign thr        = CNT_W'(FILT_CYC);
        end
    endgenerate

    always_comb begin
        q_d = q_q;
        if (!btn_low_i) begin
            q_d.run = '0;
        end else if (q_q.run < thr) begin
            q_d.run = q_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!srst_ni) begin
            q_q <= '{run: '0};
        end else begin
            q_q <= q_d;
        end
    end

    assign press_o = (q_q.run >= thr);

    // R5: a press is only ever reported after a sampled low
    a_r5_press_needs_low: assert property (@(posedge clk_i) disable iff (!srst_ni)
        press_o |-> $past(btn_low_i));

    // R7: a release removes the press on the next cycle
    a_r7_release_clears: assert property (@(posedge clk_i) disable iff (!srst_ni)
        !btn_low_i |=> !press_o);

endmodule

// File: rtl/rsup_recovery.sv
module rsup_recovery
    import rsup_pkg::*;
#(
    parameter int unsigned REC_SHORT_CYC = 10_500_000,
    parameter int unsigned REC_LONG_CYC  = 45_000_000
) (
    input  logic clk_i,
    input  logic srst_ni,
    input  logic fault_i,
    input  logic long_sel_i,
    output logic rst_no
);

    localparam int unsigned REC_W = bits_for(max2(REC_SHORT_CYC, REC_LONG_CYC));

    typedef struct packed {
        rec_state_e       st;
        logic [REC_W-1:0] cnt;
        logic             out_n;
    } rec_t;

    rec_t             r_d, r_q;
    logic [REC_W-1:0] last;

    always_comb begin
        last = long_sel_i ? REC_W'(REC_LONG_CYC - 1) : REC_W'(REC_SHORT_CYC - 1);
        r_d  = r_q;
        if (fault_i) begin
            r_d.st    = REC_HOLD;
            r_d.cnt   = '0;
            r_d.out_n = 1'b0;
        end else begin
            unique case (r_q.st)
                REC_HOLD: begin
                    r_d.st    = REC_COUNT;
                    r_d.cnt   = '0;
                    r_d.out_n = 1'b0;
                end
                REC_COUNT: begin
                    if (r_q.cnt >= last) begin
                        r_d.st    = REC_DONE;
                        r_d.out_n = 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                REC_DONE: begin
                    r_d.out_n = 1'b1;
                end
                default: begin
                    r_d.st    = REC_HOLD;
                    r_d.cnt   = '0;
                    r_d.out_n = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!srst_ni) begin
            r_q <= '{st: REC_HOLD, cnt: '0, out_n: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rst_no = r_q.out_n;

    // R3: any fault forces the reset low next cycle
    a_r3_fault_asserts: assert property (@(posedge clk_i) disable iff (!srst_ni)
        fault_i |=> !rst_no);

    // R3: release only from a completed, fault-free count
    a_r3_release_clean: assert property (@(posedge clk_i) disable iff (!srst_ni)
        $rose(rst_no) |-> ($past(!fault_i) && ($past(r_q.st) == REC_COUNT)));

    // R3: a released reset stays released while sources are clean
    a_r3_stays_released: assert property (@(posedge clk_i) disable iff (!srst_ni)
        (rst_no && !fault_i) |=> rst_no);

    // R9: a fault mid-count drops the count back to zero
    a_r9_abort_restart: assert property (@(posedge clk_i) disable iff (!srst_ni)
        ((r_q.st == REC_COUNT) && fault_i) |=> ((r_q.st == REC_HOLD) && (r_q.cnt == '0)));

endmodule

// File: rtl/rsup_ctrl.sv
module rsup_ctrl
    import rsup_pkg::*;
#(
    parameter int unsigned CLK_HZ        = 50_000_000,
    parameter int unsigned REC_SHORT_CYC = (CLK_HZ / 1000) * 210,
    parameter int unsigned REC_LONG_CYC  = (CLK_HZ / 1000) * 900,
    parameter int unsigned FILT_CYC      = max2(1, CLK_HZ / 10_000_000),
    parameter int unsigned HOLD_MIN_CYC  = max2(1, (CLK_HZ / 1_000_000) * 6),
    parameter int unsigned HOLD_W        = 32,
    parameter bit          HOLD_OPT      = 1'b1
) (
    input  logic              clk_i,
    input  logic              srst_ni,
    input  logic              pg_primary_i,
    input  logic              pg_secondary_i,
    input  logic              pg_adjust_i,
    input  logic              btn_ni,
    input  logic              cfg_long_sel_i,
    input  logic              cfg_hold_en_i,
    input  logic [HOLD_W-1:0] cfg_hold_cyc_i,
    output logic              sys_rst_no
);

    localparam int unsigned     N_SRC     = 4;
    localparam logic [N_SRC-1:0] SYNC_INIT = 4'b1000;  // button released, rails not yet good

    logic [N_SRC-1:0] raw_in;
    logic [N_SRC-1:0] sync_in;
    logic [2:0]       pg_s;
    logic             btn_low_s;
    logic             press;
    logic             fault;

    assign raw_in = {btn_ni, pg_adjust_i, pg_secondary_i, pg_primary_i};

    rsup_sync #(
        .WIDTH   (N_SRC),
        .RST_VAL (SYNC_INIT)
    ) u_sync (
        .clk_i   (clk_i),
        .srst_ni (srst_ni),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    assign pg_s      = sync_in[2:0];
    assign btn_low_s = ~sync_in[3];

    rsup_btn_qual #(
        .FILT_CYC     (FILT_CYC),
        .HOLD_MIN_CYC (HOLD_MIN_CYC),
        .HOLD_W       (HOLD_W),
        .HOLD_OPT     (HOLD_OPT)
    ) u_btn (
        .clk_i      (clk_i),
        .srst_ni    (srst_ni),
        .btn_low_i  (btn_low_s),
        .hold_en_i  (cfg_hold_en_i),
        .hold_cyc_i (cfg_hold_cyc_i),
        .press_o    (press)
    );

    assign fault = ~(&pg_s) | press;

    rsup_recovery #(
        .REC_SHORT_CYC (REC_SHORT_CYC),
        .REC_LONG_CYC  (REC_LONG_CYC)
    ) u_rec (
        .clk_i      (clk_i),
        .srst_ni    (srst_ni),
        .fault_i    (fault),
        .long_sel_i (cfg_long_sel_i),
        .rst_no     (sys_rst_no)
    );

    // R1: a synchronized rail fault reaches the output one cycle later
    a_r1_supply_fault: assert property (@(posedge clk_i) disable iff (!srst_ni)
        !(&pg_s) |=> !sys_rst_no);

    // R8: a qualified press keeps the reset low
    a_r8_press_holds: assert property (@(posedge clk_i) disable iff (!srst_ni)
        press |=> !sys_rst_no);

endmodule

// File: tb/rsup_ctrl_tb.sv
module rsup_ctrl_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  L_SHORT    = 40;
    localparam int  L_LONG     = 100;
    localparam int  FILT       = 4;
    localparam int  HMIN       = 12;
    localparam int  HW         = 16;
    localparam int  WD_CYCLES  = 150_000;

    // {pg_primary, pg_secondary, pg_adjust, btn_n, expected sys_rst_n}
    localparam logic [4:0] VEC [8] = '{
        5'b1111_1, 5'b0111_0, 5'b1011_0, 5'b1101_0,
        5'b1110_0, 5'b0011_0, 5'b0000_0, 5'b1100_0
    };

    logic          clk = 1'b0;
    logic          srst_n;
    logic          pg1, pg2, pg3, btn_n;
    logic          long_sel, hold_en;
    logic [HW-1:0] hold_cyc;
    logic          rst_n;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rsup_ctrl #(
        .REC_SHORT_CYC (L_SHORT),
        .REC_LONG_CYC  (L_LONG),
        .FILT_CYC      (FILT),
        .HOLD_MIN_CYC  (HMIN),
        .HOLD_W        (HW)
    ) dut_i (
        .clk_i          (clk),
        .srst_ni        (srst_n),
        .pg_primary_i   (pg1),
        .pg_secondary_i (pg2),
        .pg_adjust_i    (pg3),
        .btn_ni         (btn_n),
        .cfg_long_sel_i (long_sel),
        .cfg_hold_en_i  (hold_en),
        .cfg_hold_cyc_i (hold_cyc),
        .sys_rst_no     (rst_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic exp, input string tag);
        n_chk++;
        if (rst_n !== exp) begin
            n_err++;
            $display("FAIL %s: sys_rst_no=%0b expected %0b at %0t", tag, rst_n, exp, $time);
        end
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog (all requirements): still running, expected end");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        srst_n = 1'b0; pg1 = 1'b1; pg2 = 1'b1; pg3 = 1'b1; btn_n = 1'b1;
        long_sel = 1'b0; hold_en = 1'b0; hold_cyc = '0;

        // R10: reset state, then full interval before first release
        tick(3);
        check(1'b0, "R10 during reset");
        srst_n = 1'b1;
        tick(L_SHORT + 2);
        check(1'b0, "R10 before first release");
        tick(1);
        check(1'b1, "R10 first release");

        // Vector table: combinations of rails and button (R1/R2), then recovery (R3)
        for (int i = 0; i < 8; i++) begin
            {pg1, pg2, pg3, btn_n} = VEC[i][4:1];
            tick(8);
            check(VEC[i][0], "R1/R2 table");
            {pg1, pg2, pg3, btn_n} = 4'b1111;
            if (!VEC[i][0]) begin
                tick(L_SHORT + 5);
                check(1'b1, "R3 table recovery");
            end
        end

        // R1 latency and R3 exact release edge
        pg2 = 1'b0;
        tick(2);
        check(1'b1, "R1 before third edge");
        tick(1);
        check(1'b0, "R1 third edge");
        pg2 = 1'b1;
        tick(L_SHORT + 2);
        check(1'b0, "R3 one edge early");
        tick(1);
        check(1'b1, "R3 release edge");

        // R4 long interval
        long_sel = 1'b1;
        pg1 = 1'b0;
        tick(3);
        check(1'b0, "R4 assert");
        pg1 = 1'b1;
        tick(L_SHORT + 3);
        check(1'b0, "R4 not short");
        tick(L_LONG - L_SHORT - 1);
        check(1'b0, "R4 one edge early");
        tick(1);
        check(1'b1, "R4 long release");
        long_sel = 1'b0;

        // R5 glitch shorter than the filter is ignored
        btn_n = 1'b0;
        tick(FILT - 1);
        btn_n = 1'b1;
        tick(12);
        check(1'b1, "R5 glitch ignored");

        // R5 qualified press, R8 hold and release
        btn_n = 1'b0;
        tick(FILT + 2);
        check(1'b1, "R5 before filter edge");
        tick(1);
        check(1'b0, "R5 filter edge");
        tick(50);
        check(1'b0, "R8 held while pressed");
        btn_n = 1'b1;
        tick(L_SHORT + 3);
        check(1'b0, "R8 one edge early");
        tick(1);
        check(1'b1, "R8 release edge");

        // R6 hold qualifier above the floor
        hold_en  = 1'b1;
        hold_cyc = HW'(20);
        btn_n = 1'b0;
        tick(22);
        check(1'b1, "R6 before hold");
        tick(1);
        check(1'b0, "R6 hold reached");
        btn_n = 1'b1;
        tick(L_SHORT + 4);
        check(1'b1, "R6 recovered");

        // R6 request below the floor is clamped
        hold_cyc = HW'(3);
        btn_n = 1'b0;
        tick(HMIN + 2);
        check(1'b1, "R6 clamp before floor");
        tick(1);
        check(1'b0, "R6 clamp floor reached");
        btn_n = 1'b1;
        tick(L_SHORT + 4);
        check(1'b1, "R6 clamp recovered");

        // R7 two short presses do not accumulate
        hold_cyc = HW'(20);
        btn_n = 1'b0;
        tick(19);
        btn_n = 1'b1;
        tick(4);
        check(1'b1, "R7 first short press");
        btn_n = 1'b0;
        tick(19);
        btn_n = 1'b1;
        tick(10);
        check(1'b1, "R7 second short press");
        hold_en = 1'b0;

        // R9 glitch mid-count restarts the interval
        pg3 = 1'b0;
        tick(3);
        check(1'b0, "R9 initial fault");
        pg3 = 1'b1;
        tick(20);
        pg3 = 1'b0;
        tick(1);
        pg3 = 1'b1;
        tick(L_SHORT + 2);
        check(1'b0, "R9 count restarted");
        tick(1);
        check(1'b1, "R9 release after restart");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule